// File: doc/BRIEF.md
# SDRAM Open-Row Bank Manager

This block sits between an address decoder and a column-transfer stage of an SDRAM controller. It takes one decoded access at a time: bank, row, column, direction, length and an auto-precharge flag. It keeps the state of every bank: whether the bank is idle or active, and which row it holds. From that state it decides whether the access can go straight to the transfer stage, or whether the bank must first be precharged and re-activated.

A row stays open after it has been used, so back-to-back accesses to the same row of a bank cost no row commands. Each bank is handled on its own. The block drives row-level commands (no-operation, activate, precharge, refresh) on a small command port. It enforces the activate-to-column, precharge-to-activate, activate-to-precharge, auto-precharge recovery and refresh-recovery spacing with per-bank and global down-counters. It hands row hits downstream through a valid/ready handshake.

A one-cycle refresh pulse is remembered until it has been served. It is served once the access in progress has been handed off: the block closes every bank with a single precharge-all, then issues the refresh.

Top module: `sdbk_row_manager`

## Requirements
- R1: While reset is held and on the first cycle after it, the command port shows no-operation, `xfer_valid` is 0, `req_ready` is 1, and every bank is idle.
- R2: An access to an idle bank produces an activate (`cmd_code` 1) with the bank on `cmd_bank` and the row on `cmd_addr`. It is issued only once that bank's precharge or auto-precharge recovery time has passed and the refresh recovery time (T_RFC cycles after a refresh) has passed.
- R3: An access whose row is already open in its bank raises `xfer_valid` with no row command in between, but not earlier than T_RCD cycles after that bank's activate.
- R4: An access to a different row of an active bank first produces a single-bank precharge (`cmd_code` 2, `cmd_addr` bit 10 low), not earlier than T_RAS cycles after the bank's activate. An activate of the new row follows no earlier than T_RP cycles later.
- R5: A precharge or activate of one bank leaves the open rows of the other banks untouched, so later hits to those banks go through without row commands.
- R6: A refresh pulse on `ref_req` stops new accesses from being accepted once the current one is handed off. If any bank is open, a precharge-all (`cmd_code` 2, `cmd_addr` bit 10 high) is issued once every open bank has met T_RAS. A refresh (`cmd_code` 3) follows when every bank has met its precharge time, and `ref_ack` is 1 in exactly that cycle.
- R7: No activate and no further refresh is issued in the T_RFC-1 cycles that follow a refresh.
- R8: A hand-off with `req_autopre` set marks that bank idle. The next access to it needs an activate with no precharge, issued no earlier than T_APRE cycles after the hand-off.
- R9: The command code is 0 for no-operation, 1 for activate, 2 for precharge and 3 for refresh. Every cycle without a required command shows 0.
- R10: `req_ready` is 0 while an access is held. While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid` stays 1 and the transfer fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Decoded access offered |
| req_ready | output | 1 | Access accepted this cycle when valid |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Start column |
| req_write | input | 1 | 1 for write, 0 for read |
| req_len | input | LEN_W | Transfer length |
| req_autopre | input | 1 | Close the bank after this transfer |
| ref_req | input | 1 | One-cycle refresh request pulse |
| ref_ack | output | 1 | High in the cycle the refresh command is driven |
| cmd_code | output | 2 | Row command: 0 NOP, 1 ACT, 2 PRE, 3 REF |
| cmd_bank | output | BA_W | Bank of the row command |
| cmd_addr | output | ADDR_W | Row for activate; bit 10 selects precharge-all |
| xfer_valid | output | 1 | Row hit ready for the transfer stage |
| xfer_ready | input | 1 | Transfer stage takes the access |
| xfer_bank | output | BA_W | Bank of the forwarded access |
| xfer_col | output | COL_W | Column of the forwarded access |
| xfer_write | output | 1 | Direction of the forwarded access |
| xfer_len | output | LEN_W | Length of the forwarded access |
| xfer_autopre | output | 1 | Auto-precharge flag of the forwarded access |

## Verification
The bench builds the block with T_RCD=2, T_RP=3, T_RAS=5, T_RFC=6 and T_APRE=4, and with a 12-bit row. Because these windows are short, a stimulus stream drawing rows from only three values per bank hits every timing limit often. It reaches row hits made to wait for T_RCD, misses held back by T_RAS, activates stalled only by refresh recovery, and auto-precharge reopenings, all within a few thousand cycles. With four banks and frequent refresh pulses, the bench also sees many precharge-all commands issued while several rows are open, as well as hits on one bank between row commands to another.

// File: rtl/sdbk_pkg.sv
// Shared definitions for the SDRAM open-row bank manager.
// Assumes: command encoding is fixed by the downstream command driver.
package sdbk_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_PRE = 2'd2,
        CMD_REF = 2'd3
    } sdbk_cmd_e;

    // Address bit that selects all banks on a precharge
    localparam int ALL_BANK_BIT = 10;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdbk_bank_track.sv
// Per-bank state: open flag, open row and three timing down-counters.
// Assumes: the scheduler never asserts act_i together with pre_i/apre_i,
// and every timing parameter is at least 1.
module sdbk_bank_track #(
    parameter int ROW_W  = 13,
    parameter int CNT_W  = 4,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 7,
    parameter int T_APRE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             apre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o
);

    localparam logic [CNT_W-1:0] RCD_LD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RAS_LD  = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] APRE_LD = CNT_W'(T_APRE - 1);

    logic [CNT_W-1:0] rcd_cnt, ras_cnt, rp_cnt;

    // Open flag and open row follow activate and both kinds of close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (pre_i || apre_i) begin
            open_o <= 1'b0;
        end
    end

    // Activate-to-column and activate-to-precharge counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            ras_cnt <= '0;
        end else if (act_i) begin
            rcd_cnt <= RCD_LD;
            ras_cnt <= RAS_LD;
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
        end
    end

    // Close-to-activate counter, loaded by precharge or auto-precharge
    always_ff @(posedge clk) begin
        if (!rst_n)            rp_cnt <= '0;
        else if (pre_i)        rp_cnt <= RP_LD;
        else if (apre_i)       rp_cnt <= APRE_LD;
        else if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
    end

    assign col_ok_o = (rcd_cnt == '0);
    assign pre_ok_o = (ras_cnt == '0);
    assign act_ok_o = !open_o && (rp_cnt == '0);

endmodule

// File: rtl/sdbk_sched.sv
// Request slot, refresh bookkeeping and per-cycle command decision.
// Assumes: bank state arrives from sdbk_bank_track instances; the
// command decision depends only on registers plus xfer_ready.
module sdbk_sched
    import sdbk_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BA_W   = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 4,
    parameter int T_RFC  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [BA_W-1:0]        req_bank,
    input  logic [ROW_W-1:0]       req_row,
    input  logic [COL_W-1:0]       req_col,
    input  logic                   req_write,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_autopre,
    input  logic                   ref_req,
    output logic                   ref_ack,
    output logic [1:0]             cmd_code,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [ADDR_W-1:0]      cmd_addr,
    output logic                   xfer_valid,
    input  logic                   xfer_ready,
    output logic [BA_W-1:0]        xfer_bank,
    output logic [COL_W-1:0]       xfer_col,
    output logic                   xfer_write,
    output logic [LEN_W-1:0]       xfer_len,
    output logic                   xfer_autopre,
    input  logic [NBANK-1:0]       bank_open,
    input  logic [NBANK*ROW_W-1:0] bank_row,
    input  logic [NBANK-1:0]       bank_col_ok,
    input  logic [NBANK-1:0]       bank_pre_ok,
    input  logic [NBANK-1:0]       bank_act_ok,
    output logic [NBANK-1:0]       act_v,
    output logic [NBANK-1:0]       pre_v,
    output logic [NBANK-1:0]       apre_v,
    output logic [ROW_W-1:0]       act_row
);

    localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

    logic               s_valid;
    logic [BA_W-1:0]    s_bank;
    logic [ROW_W-1:0]   s_row;
    logic [COL_W-1:0]   s_col;
    logic               s_write;
    logic [LEN_W-1:0]   s_len;
    logic               s_ap;
    logic               ref_pend;
    logic [CNT_W-1:0]   rfc_cnt;
    logic               take, issue_ref, accept;
    logic [ROW_W-1:0]   cur_row;
    sdbk_cmd_e          cmd;

    assign req_ready = !s_valid && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign cur_row   = bank_row[s_bank*ROW_W +: ROW_W];

    // Hold one accepted access until it is handed to the transfer stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_bank  <= '0;
            s_row   <= '0;
            s_col   <= '0;
            s_write <= 1'b0;
            s_len   <= '0;
            s_ap    <= 1'b0;
        end else if (accept) begin
            s_valid <= 1'b1;
            s_bank  <= req_bank;
            s_row   <= req_row;
            s_col   <= req_col;
            s_write <= req_write;
            s_len   <= req_len;
            s_ap    <= req_autopre;
        end else if (take) begin
            s_valid <= 1'b0;
        end
    end

    // Remember a refresh pulse until the refresh command goes out
    always_ff @(posedge clk) begin
        if (!rst_n) ref_pend <= 1'b0;
        else        ref_pend <= ref_req || (ref_pend && !issue_ref);
    end

    // Refresh recovery counter, shared by all banks
    always_ff @(posedge clk) begin
        if (!rst_n)             rfc_cnt <= '0;
        else if (issue_ref)     rfc_cnt <= RFC_LD;
        else if (rfc_cnt != '0) rfc_cnt <= rfc_cnt - 1'b1;
    end

    // Pick this cycle's row command or hand-off from slot and bank state
    always_comb begin
        cmd        = CMD_NOP;
        cmd_bank   = '0;
        cmd_addr   = '0;
        act_v      = '0;
        pre_v      = '0;
        apre_v     = '0;
        xfer_valid = 1'b0;
        issue_ref  = 1'b0;
        take       = 1'b0;
        if (!s_valid && ref_pend) begin
            if (|bank_open) begin
                if ((bank_open & ~bank_pre_ok) == '0) begin
                    cmd                    = CMD_PRE;
                    cmd_addr[ALL_BANK_BIT] = 1'b1;
                    pre_v                  = '1;
                end
            end else if ((&bank_act_ok) && (rfc_cnt == '0)) begin
                cmd       = CMD_REF;
                issue_ref = 1'b1;
            end
        end else if (s_valid) begin
            if (bank_open[s_bank]) begin
                if (cur_row == s_row) begin
                    if (bank_col_ok[s_bank]) begin
                        xfer_valid = 1'b1;
                        if (xfer_ready) begin
                            take           = 1'b1;
                            apre_v[s_bank] = s_ap;
                        end
                    end
                end else if (bank_pre_ok[s_bank]) begin
                    cmd           = CMD_PRE;
                    cmd_bank      = s_bank;
                    pre_v[s_bank] = 1'b1;
                end
            end else if (bank_act_ok[s_bank] && (rfc_cnt == '0)) begin
                cmd           = CMD_ACT;
                cmd_bank      = s_bank;
                cmd_addr      = ADDR_W'(s_row);
                act_v[s_bank] = 1'b1;
            end
        end
    end

    assign cmd_code     = cmd;
    assign ref_ack      = issue_ref;
    assign act_row      = s_row;
    assign xfer_bank    = s_bank;
    assign xfer_col     = s_col;
    assign xfer_write   = s_write;
    assign xfer_len     = s_len;
    assign xfer_autopre = s_ap;

endmodule

// File: rtl/sdbk_row_manager.sv
// Top of the open-row bank manager: one tracker per bank plus the
// scheduler. Assumes: all timing parameters are at least 2 and
// ROW_W is at least 11 so the all-bank address bit exists.
module sdbk_row_manager
    import sdbk_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int LEN_W  = 4,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 7,
    parameter int T_RFC  = 8,
    parameter int T_APRE = 5,
    localparam int BA_W   = $clog2(NBANK),
    localparam int ADDR_W = imax(ROW_W, ALL_BANK_BIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_autopre,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic [1:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [BA_W-1:0]   xfer_bank,
    output logic [COL_W-1:0]  xfer_col,
    output logic              xfer_write,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_autopre
);

    localparam int TMAX  = imax(imax(imax(T_RCD, T_RP), imax(T_RAS, T_RFC)), T_APRE);
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [NBANK-1:0]       bank_open, bank_col_ok, bank_pre_ok, bank_act_ok;
    logic [NBANK-1:0]       act_v, pre_v, apre_v;
    logic [NBANK*ROW_W-1:0] bank_row;
    logic [ROW_W-1:0]       act_row;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdbk_bank_track #(
            .ROW_W (ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD),
            .T_RP  (T_RP),  .T_RAS(T_RAS), .T_APRE(T_APRE)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_v[b]),
            .pre_i    (pre_v[b]),
            .apre_i   (apre_v[b]),
            .row_i    (act_row),
            .open_o   (bank_open[b]),
            .row_o    (bank_row[b*ROW_W +: ROW_W]),
            .col_ok_o (bank_col_ok[b]),
            .pre_ok_o (bank_pre_ok[b]),
            .act_ok_o (bank_act_ok[b])
        );
    end

    sdbk_sched #(
        .NBANK(NBANK), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_RFC(T_RFC)
    ) u_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_write    (req_write),
        .req_len      (req_len),
        .req_autopre  (req_autopre),
        .ref_req      (ref_req),
        .ref_ack      (ref_ack),
        .cmd_code     (cmd_code),
        .cmd_bank     (cmd_bank),
        .cmd_addr     (cmd_addr),
        .xfer_valid   (xfer_valid),
        .xfer_ready   (xfer_ready),
        .xfer_bank    (xfer_bank),
        .xfer_col     (xfer_col),
        .xfer_write   (xfer_write),
        .xfer_len     (xfer_len),
        .xfer_autopre (xfer_autopre),
        .bank_open    (bank_open),
        .bank_row     (bank_row),
        .bank_col_ok  (bank_col_ok),
        .bank_pre_ok  (bank_pre_ok),
        .bank_act_ok  (bank_act_ok),
        .act_v        (act_v),
        .pre_v        (pre_v),
        .apre_v       (apre_v),
        .act_row      (act_row)
    );

endmodule

// File: rtl/sdbk_row_manager_chk.sv
// Port-level protocol checks for sdbk_row_manager, attached by bind.
// Assumes: all timing parameters are at least 2.
module sdbk_row_manager_chk #(
    parameter int BA_W   = 2,
    parameter int COL_W  = 10,
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              ref_ack,
    input logic [1:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [BA_W-1:0]   xfer_bank,
    input logic [COL_W-1:0]  xfer_col,
    input logic              xfer_write,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              xfer_autopre
);

    // R10
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_bank) &&
        $stable(xfer_col) && $stable(xfer_write) && $stable(xfer_len) &&
        $stable(xfer_autopre));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !req_ready);

    // R6
    ack_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> cmd_code == 2'd3);

    // R6
    pre_all_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 2'd2) && cmd_addr[10] |-> !req_ready && !xfer_valid);

    // R7
    no_act_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code == 2'd3 |=> cmd_code != 2'd1 && cmd_code != 2'd3);

    // R3
    no_col_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code == 2'd1 |=> !xfer_valid && cmd_code != 2'd2);

endmodule

bind sdbk_row_manager sdbk_row_manager_chk #(
    .BA_W(BA_W), .COL_W(COL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sdbk_row_manager_tb.sv
// Bench: behavioural reference model compared on every clock.
module sdbk_row_manager_tb_top;

    localparam int NB = 4, ROW_W = 12, COL_W = 10, LEN_W = 4;
    localparam int T_RCD = 2, T_RP = 3, T_RAS = 5, T_RFC = 6, T_APRE = 4;
    localparam int CYCLES = 6000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_autopre = 0, ref_req = 0, xfer_ready = 0;
    logic [1:0] req_bank = 0;
    logic [ROW_W-1:0] req_row = 0;
    logic [COL_W-1:0] req_col = 0;
    logic [LEN_W-1:0] req_len = 0;
    logic req_ready, ref_ack, xfer_valid, xfer_write, xfer_autopre;
    logic [1:0] cmd_code, cmd_bank, xfer_bank;
    logic [ROW_W-1:0] cmd_addr;
    logic [COL_W-1:0] xfer_col;
    logic [LEN_W-1:0] xfer_len;

    always #10 clk = ~clk;

    sdbk_row_manager #(.NBANK(NB), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC), .T_APRE(T_APRE)
    ) dut_i (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_open[NB], m_row[NB], m_rcd[NB], m_ras[NB], m_rp[NB];
    int m_rfc, m_refp, m_slot, m_b, m_r, m_c, m_w, m_l, m_ap;
    int e_cmd, e_bank, e_addr, e_xv, e_ack, e_rdy, e_hand;
    int acc_flag;
    int n_act, n_pre1, n_preall, n_ref, n_hand, n_ap, n_multi, n_rfcblk;
    int unsigned rs = 32'h1234_5678;

    function automatic int unsigned rnd();
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        return rs;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = 0; m_rcd[b] = 0; m_ras[b] = 0; m_rp[b] = 0;
        end
        m_rfc = 0; m_refp = 0; m_slot = 0; acc_flag = 0;
    endtask

    task automatic model_eval();
        int any_open, blocked, all_rp;
        e_cmd = 0; e_bank = 0; e_addr = 0; e_xv = 0; e_ack = 0; e_hand = 0;
        e_rdy = (!m_slot && !m_refp) ? 1 : 0;
        if (!m_slot && m_refp) begin
            any_open = 0; blocked = 0; all_rp = 1;
            for (int b = 0; b < NB; b++) begin
                if (m_open[b] != 0) any_open = 1;
                if (m_open[b] != 0 && m_ras[b] != 0) blocked = 1;
                if (m_rp[b] != 0) all_rp = 0;
            end
            if (any_open != 0) begin
                if (blocked == 0) begin e_cmd = 2; e_addr = 1 << 10; end
            end else if (all_rp != 0 && m_rfc == 0) begin
                e_cmd = 3; e_ack = 1;
            end
        end else if (m_slot != 0) begin
            if (m_open[m_b] != 0) begin
                if (m_row[m_b] == m_r) begin
                    if (m_rcd[m_b] == 0) begin e_xv = 1; e_hand = xfer_ready ? 1 : 0; end
                end else if (m_ras[m_b] == 0) begin
                    e_cmd = 2; e_bank = m_b;
                end
            end else if (m_rp[m_b] == 0 && m_rfc == 0) begin
                e_cmd = 1; e_bank = m_b; e_addr = m_r;
            end else if (m_rp[m_b] == 0) begin
                n_rfcblk++;
            end
        end
    endtask

    task automatic model_step();
        int nopen;
        model_eval();
        for (int b = 0; b < NB; b++) begin
            if (m_rcd[b] > 0) m_rcd[b]--;
            if (m_ras[b] > 0) m_ras[b]--;
            if (m_rp[b] > 0) m_rp[b]--;
        end
        if (m_rfc > 0) m_rfc--;
        if (e_cmd == 1) begin
            m_open[m_b] = 1; m_row[m_b] = m_r; m_rcd[m_b] = T_RCD - 1; m_ras[m_b] = T_RAS - 1;
            n_act++;
        end else if (e_cmd == 2 && e_addr != 0) begin
            for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_rp[b] = T_RP - 1; end
            n_preall++;
        end else if (e_cmd == 2) begin
            m_open[m_b] = 0; m_rp[m_b] = T_RP - 1; n_pre1++;
        end else if (e_cmd == 3) begin
            m_rfc = T_RFC - 1; n_ref++;
        end
        if (e_hand != 0) begin
            nopen = 0;
            for (int b = 0; b < NB; b++) nopen += m_open[b];
            if (nopen >= 2) n_multi++;
            n_hand++;
            m_slot = 0;
            if (m_ap != 0) begin m_open[m_b] = 0; m_rp[m_b] = T_APRE - 1; n_ap++; end
        end
        m_refp = (ref_req || (m_refp != 0 && e_ack == 0)) ? 1 : 0;
        acc_flag = 0;
        if (req_valid && e_rdy != 0) begin
            m_slot = 1; m_b = req_bank; m_r = req_row; m_c = req_col;
            m_w = req_write; m_l = req_len; m_ap = req_autopre; acc_flag = 1;
        end
    endtask

    always @(posedge clk) if (rst_n) model_step();

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        string tag;
        model_eval();
        case (e_cmd)
            1: tag = "R2";
            2: tag = (e_addr != 0) ? "R6" : "R4";
            3: tag = "R7";
            default: tag = "R9";
        endcase
        chk(int'(cmd_code) == e_cmd, tag, "cmd_code", int'(cmd_code), e_cmd);
        if (e_cmd == 1 || (e_cmd == 2 && e_addr == 0))
            chk(int'(cmd_bank) == e_bank, tag, "cmd_bank", int'(cmd_bank), e_bank);
        if (e_cmd == 1 || e_cmd == 2)
            chk(int'(cmd_addr) == e_addr, tag, "cmd_addr", int'(cmd_addr), e_addr);
        chk(int'(xfer_valid) == e_xv, "R3", "xfer_valid", int'(xfer_valid), e_xv);
        chk(int'(req_ready) == e_rdy, "R10", "req_ready", int'(req_ready), e_rdy);
        chk(int'(ref_ack) == e_ack, "R6", "ref_ack", int'(ref_ack), e_ack);
        if (e_xv != 0) begin
            chk(int'(xfer_bank) == m_b && int'(xfer_col) == m_c && int'(xfer_write) == m_w
                && int'(xfer_len) == m_l && int'(xfer_autopre) == m_ap,
                "R10", "xfer fields col", int'(xfer_col), m_c);
        end
    endtask

    task automatic drive();
        int unsigned x;
        ref_req = 0;
        if (acc_flag != 0) req_valid = 0;
        x = rnd();
        if (!req_valid && (x % 3) != 0) begin
            req_valid = 1;
            req_bank = 2'(rnd() % NB);
            req_row = ROW_W'(rnd() % 3);
            req_col = COL_W'(rnd());
            req_len = LEN_W'(rnd());
            req_write = rnd() % 2 == 0;
            req_autopre = rnd() % 7 == 0;
        end
        xfer_ready = (rnd() % 4) != 0;
        if (rnd() % 60 == 0) ref_req = 1;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(cmd_code == 2'd0 && !xfer_valid && req_ready && !ref_ack, "R1",
            "reset outputs cmd", int'(cmd_code), 0);
        rst_n = 1;
        @(negedge clk);
        // R1: first cycle after reset
        chk(cmd_code == 2'd0 && !xfer_valid && req_ready, "R1",
            "post-reset idle cmd", int'(cmd_code), 0);
        for (int i = 0; i < CYCLES; i++) begin
            compare();
            drive();
            @(negedge clk);
        end
        // coverage of the paths behind each requirement
        chk(n_act > 0, "R2", "activates seen", n_act, 1);
        chk(n_pre1 > 0, "R4", "single precharges seen", n_pre1, 1);
        chk(n_preall > 0, "R6", "precharge-all seen", n_preall, 1);
        chk(n_ref > 0, "R6", "refreshes seen", n_ref, 1);
        chk(n_multi > 0, "R5", "hits with several banks open", n_multi, 1);
        chk(n_rfcblk > 0, "R7", "activates held by refresh recovery", n_rfcblk, 1);
        chk(n_ap > 0, "R8", "auto-precharge hand-offs", n_ap, 1);
        chk(n_hand > 0, "R3", "hand-offs", n_hand, 1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule